// File: doc/BRIEF.md
# Fixed-Period PWM Current Chopper

This block turns two digital current-comparator trip signals into the chopping waveform for the two H-bridge windings of a bipolar stepper drive. A free-running 8-bit counter fixes the chopping period at 256 clocks. At the start of each period both windings turn on and an active-low sync pulse is sent out. After a programmable blanking interval the block samples each trip input. The first trip it samples turns that winding off until the next period begins.

A mode input picks the decay style. In slow decay the active phase leg of each bridge is chopped and the inhibit lines stay released. In fast decay the phase leg is held on and the bridge's inhibit line is chopped instead. A polarity bit per winding chooses which leg of the pair is active. An active-low enable forces all six drive lines low.

An idle timer counts clocks since the last step event. Once the programmed delay has run out, it raises a select bit that switches the external comparators to a reduced holding-current reference. The next step event clears that bit again.

Top module: `pwm_chopper`

## Requirements
- R1: The period counter is 0 at reset and advances by one on every clock. `sync_n` is low exactly while the counter is 0, so it is low during reset and for one clock in every 256.
- R2: A trip input is sampled only while the counter is at least `blank_len` and not equal to 255. With `blank_len` = 255, trips are never sampled and both windings stay on for the whole period.
- R3: When a winding samples a trip at counter value k, it is off from counter value k+1 until the end of the period. It is back on when the counter returns to 0. `trip1` affects only winding 1 (A/B, `inh1_n`) and `trip2` affects only winding 2 (C/D, `inh2_n`).
- R4: With `fast_decay` = 0 and enable active, the active leg of each bridge follows the winding's on state, and `inh1_n`/`inh2_n` are 1.
- R5: With `fast_decay` = 1 and enable active, the active leg of each bridge is 1, and the bridge's inhibit line equals the winding's on state (0 while the winding is off).
- R6: `pol1` = 1 makes `pha` the active leg of bridge 1 with `phb` held 0; `pol1` = 0 makes `phb` active with `pha` held 0. `pol2` does the same for `phc`/`phd`.
- R7: While `en_n` is 1, `pha`, `phb`, `phc`, `phd`, `inh1_n` and `inh2_n` are all 0. The period counter, the off latches and the hold timer keep running.
- R8: `hold_sel` rises at the (`hold_len`+1)-th clock edge after the last edge at which `step` was sampled high, or after reset is released. It then stays 1 until the next step.
- R9: A step sampled high clears `hold_sel` at that clock edge and restarts the hold delay.
- R10: During reset both windings are on, `hold_sel` is 0 and `sync_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low drive enable |
| fast_decay | input | 1 | 1 = chop inhibit lines, 0 = chop phase legs |
| trip1 | input | 1 | Current trip, winding 1 |
| trip2 | input | 1 | Current trip, winding 2 |
| blank_len | input | 8 | Blanking length in clocks (255 = never sample) |
| hold_len | input | HOLD_W | Idle clocks before the holding reference |
| step | input | 1 | Step event pulse |
| pol1 | input | 1 | Winding 1 polarity (1 = A active) |
| pol2 | input | 1 | Winding 2 polarity (1 = C active) |
| pha | output | 1 | Bridge 1 leg A |
| phb | output | 1 | Bridge 1 leg B |
| phc | output | 1 | Bridge 2 leg C |
| phd | output | 1 | Bridge 2 leg D |
| inh1_n | output | 1 | Active-low inhibit, bridge 1 |
| inh2_n | output | 1 | Active-low inhibit, bridge 2 |
| sync_n | output | 1 | Active-low start-of-period pulse |
| hold_sel | output | 1 | 1 = holding reference selected |

## Verification
The assertions assume that the decay mode, the polarity bits and the enable change only between clock edges. They also assume that all inputs are synchronous to `clk`, so that the output relations they check are stable within a cycle. The stimulus drives every input at the falling edge and holds each mode configuration for a long segment. Trips and steps are random, short pulses. The segments include directed cases for `blank_len` of 0 and 255, a disabled segment, and a hold delay of zero.

// File: rtl/pwm_chopper.sv
module pwm_chopper #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              fast_decay,
  input  logic              trip1,
  input  logic              trip2,
  input  logic [7:0]        blank_len,
  input  logic [HOLD_W-1:0] hold_len,
  input  logic              step,
  input  logic              pol1,
  input  logic              pol2,
  output logic              pha,
  output logic              phb,
  output logic              phc,
  output logic              phd,
  output logic              inh1_n,
  output logic              inh2_n,
  output logic              sync_n,
  output logic              hold_sel
);
  localparam int CW = 8;
  localparam logic [CW-1:0] LAST = '1;

  logic [CW-1:0]     cnt;
  logic [1:0]        off;
  logic [HOLD_W-1:0] hcnt;

  wire       sample = (cnt >= blank_len) && (cnt != LAST);
  wire [1:0] on     = ~off;
  wire [1:0] act    = fast_decay ? 2'b11 : on;
  wire [1:0] inh    = fast_decay ? on : 2'b11;
  wire       en     = ~en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      off <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) off <= '0;
      else             off <= off | ({trip2, trip1} & {2{sample}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt     <= '0;
      hold_sel <= 1'b0;
    end else if (step) begin
      hcnt     <= '0;
      hold_sel <= 1'b0;
    end else if (!hold_sel) begin
      if (hcnt == hold_len) hold_sel <= 1'b1;
      else                  hcnt     <= hcnt + 1'b1;
    end
  end

  assign sync_n = (cnt != '0);
  assign pha    = en &  pol1 & act[0];
  assign phb    = en & ~pol1 & act[0];
  assign phc    = en &  pol2 & act[1];
  assign phd    = en & ~pol2 & act[1];
  assign inh1_n = en & inh[0];
  assign inh2_n = en & inh[1];
endmodule

module pwm_chopper_chk (
  input logic clk,
  input logic rst_n,
  input logic en_n,
  input logic fast_decay,
  input logic step,
  input logic pha,
  input logic phb,
  input logic phc,
  input logic phd,
  input logic inh1_n,
  input logic inh2_n,
  input logic sync_n,
  input logic hold_sel
);
  logic [8:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap <= '0;
    else if (!sync_n) gap <= 9'd1;
    else              gap <= gap + 1'b1;
  end

  p_sync_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && gap != 0) |-> gap == 9'd256);
  p_sync_late_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> gap < 9'd256);
  p_legs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pha, phb}) && $onehot0({phc, phd}));
  p_slow_inh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !fast_decay) |-> (inh1_n && inh2_n));
  p_fast_leg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && fast_decay) |-> ((pha | phb) && (phc | phd)));
  p_start_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !sync_n) |-> ((pha | phb) && (phc | phd) && inh1_n && inh2_n));
  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> $countones({pha, phb, phc, phd, inh1_n, inh2_n}) == 0);
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !hold_sel);
endmodule

bind pwm_chopper pwm_chopper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .fast_decay(fast_decay), .step(step),
  .pha(pha), .phb(phb), .phc(phc), .phd(phd), .inh1_n(inh1_n), .inh2_n(inh2_n),
  .sync_n(sync_n), .hold_sel(hold_sel)
);

// File: tb/pwm_chopper_tb.sv
module pwm_chopper_tb;
  localparam int HW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b0, fast_decay = 1'b0, trip1 = 1'b0, trip2 = 1'b0, step = 1'b0;
  logic pol1 = 1'b1, pol2 = 1'b1;
  logic [7:0] blank_len = 8'd10;
  logic [HW-1:0] hold_len = 16'd20;
  logic pha, phb, phc, phd, inh1_n, inh2_n, sync_n, hold_sel;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwm_chopper #(.HOLD_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .fast_decay(fast_decay),
    .trip1(trip1), .trip2(trip2), .blank_len(blank_len), .hold_len(hold_len),
    .step(step), .pol1(pol1), .pol2(pol2), .pha(pha), .phb(phb), .phc(phc),
    .phd(phd), .inh1_n(inh1_n), .inh2_n(inh2_n), .sync_n(sync_n), .hold_sel(hold_sel));

  // reference state built from the requirements
  int m_cnt, m_hcnt;
  logic [1:0] m_off;
  logic m_hold;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_off = 2'b00; m_hcnt = 0; m_hold = 1'b0;
    end else begin
      if (m_cnt == 255) m_off = 2'b00;
      else if (m_cnt >= int'(blank_len)) begin
        if (trip1) m_off[0] = 1'b1;
        if (trip2) m_off[1] = 1'b1;
      end
      m_cnt = (m_cnt + 1) % 256;
      if (step) begin m_hcnt = 0; m_hold = 1'b0; end
      else if (!m_hold) begin
        if (m_hcnt == int'(hold_len)) m_hold = 1'b1;
        else m_hcnt = m_hcnt + 1;
      end
    end
  end

  function automatic logic [5:0] exp_drive(logic e_n, logic fd, logic p1, logic p2, logic [1:0] off);
    logic [1:0] on;
    logic a1, a2, i1, i2;
    on = ~off;
    if (e_n) return 6'b0;
    a1 = fd ? 1'b1 : on[0];
    a2 = fd ? 1'b1 : on[1];
    i1 = fd ? on[0] : 1'b1;
    i2 = fd ? on[1] : 1'b1;
    return {p1 & a1, ~p1 & a1, p2 & a2, ~p2 & a2, i1, i2};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (cnt %0d)", req, act, exp, m_cnt);
    end
  endtask

  task automatic check_all();
    string tag;
    tag = en_n ? "R7 R2 R3" : (fast_decay ? "R5 R6 R2 R3" : "R4 R6 R2 R3");
    chk("R1 sync", {7'b0, sync_n}, {7'b0, m_cnt != 0});
    chk(tag, {2'b0, pha, phb, phc, phd, inh1_n, inh2_n},
        {2'b0, exp_drive(en_n, fast_decay, pol1, pol2, m_off)});
    chk("R8 R9 hold_sel", {7'b0, hold_sel}, {7'b0, m_hold});
  endtask

  task automatic run_seg(int cycles, int trip_pct, int step_pct, bit trip_stuck);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_all();
      trip1 = trip_stuck ? 1'b1 : (($urandom % 100) < trip_pct);
      trip2 = trip_stuck ? 1'b1 : (($urandom % 100) < trip_pct);
      step  = (($urandom % 1000) < step_pct);
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 sync_n", {7'b0, sync_n}, 8'd0);
    chk("R10 hold_sel", {7'b0, hold_sel}, 8'd0);
    chk("R10 drive", {2'b0, pha, phb, phc, phd, inh1_n, inh2_n}, 8'b0010_1011);
    rst_n = 1'b1;
    // directed: R2 blank 255 with trips stuck high keeps windings on
    blank_len = 8'd255; fast_decay = 1'b0; hold_len = 16'd5;
    run_seg(600, 0, 0, 1'b1);
    // directed: blank 0, fast decay, stuck trips
    blank_len = 8'd0; fast_decay = 1'b1; pol1 = 1'b0;
    run_seg(300, 0, 0, 1'b1);
    // directed: disabled drive R7, hold delay zero R8
    en_n = 1'b1; hold_len = 16'd0;
    run_seg(300, 10, 20, 1'b0);
    en_n = 1'b0;
    // random segments
    for (int s = 0; s < 16; s++) begin
      blank_len  = (s % 5 == 0) ? 8'd254 : 8'($urandom % 200);
      fast_decay = $urandom % 2;
      pol1       = $urandom % 2;
      pol2       = $urandom % 2;
      hold_len   = 16'($urandom % 60);
      en_n       = (($urandom % 8) == 0);
      run_seg(520, 2, 8, 1'b0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule